// File: doc/BRIEF.md
# Low-Power Clock Rate Controller

This block turns a free-running oscillator tick into the enable that paces the CPU core. The CPU normally gets one clock enable for every five oscillator ticks. When the core goes to its low-power wait state, the rate drops to one enable per forty ticks. Software can also pick the slow rate while running, through a one-bit speed setting written over a small register write port. The divide ratio changes only when a divider period completes, so the CPU never sees a short period.

The controller follows the core through four modes: run, wait, stop and stop recovery. A wait request moves it into wait mode. On entry it sends the core a single pulse that clears the interrupt mask, so that an interrupt can end the wait. An interrupt, or a timer event whose wake enable is set, returns it to run at the rate held in the speed setting. A reset wake-up clears the speed setting instead. A stop request halts the CPU clock completely. A wake event in stop starts a recovery delay, counted in slow-rate CPU cycles. When the delay ends, a one-cycle done flag tells the core it may fetch its vector, and the clock enable resumes.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: In run mode with the speed setting at 0, `cpu_ce` pulses once every 5 oscillator ticks, and only in a cycle where `osc_tick` is high.
- R2: A write with `wr_en` high and `wr_addr` equal to 0x21 stores `wr_spd` as the speed setting. With the setting at 1 in run mode, `cpu_ce` pulses once every 40 ticks. Writes to any other address change nothing.
- R3: A new divide ratio takes effect only at the end of the divider period in progress. A period that is under way when the ratio request changes completes at its old length.
- R4: A one-cycle `wait_req` in run mode enters wait mode. `imask_clr` is high for exactly the first cycle in wait. While in wait, `cpu_ce` pulses once every 40 ticks whatever the speed setting is.
- R5: In wait mode, an `irq_wake` pulse, or a `tmr_wake` pulse while `tmr_wake_en` is 1, returns the block to run mode at the rate given by the speed setting. A `tmr_wake` pulse while `tmr_wake_en` is 0 leaves the block in wait.
- R6: A speed write made during wait is stored, but the rate stays at 40 ticks until wake-up. The written value sets the rate after wake-up.
- R7: A `rst_wake` pulse in wait or stop mode clears the speed setting to 0. The block then runs at 5 ticks per enable once it is back in run mode.
- R8: After a one-cycle `stop_req` in run mode, `cpu_ce` stays low while stopped, and a `wait_req` in stop mode has no effect.
- R9: In stop mode, an `irq_wake` or `rst_wake` pulse starts the recovery delay. `recov_done` goes high for exactly one cycle, on the (RECOV_CYC × 40)-th oscillator tick after the wake cycle. `cpu_ce` stays low until that point and resumes afterwards.
- R10: While `rst_n` is low and after it is released, `cpu_ce`, `imask_clr` and `recov_done` are low. The speed setting resets to 0, so the first rate is 5 ticks per enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| osc_tick | input | 1 | One-cycle oscillator tick |
| wait_req | input | 1 | Request from the core to enter wait mode |
| stop_req | input | 1 | Request from the core to enter stop mode |
| irq_wake | input | 1 | Interrupt wake-up event |
| tmr_wake | input | 1 | Periodic timer wake-up event |
| tmr_wake_en | input | 1 | Lets `tmr_wake` end wait mode |
| rst_wake | input | 1 | Reset wake-up event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_spd | input | 1 | Speed setting value to write (1 = slow) |
| cpu_ce | output | 1 | CPU clock enable |
| imask_clr | output | 1 | One-cycle interrupt-mask clear pulse on wait entry |
| recov_done | output | 1 | One-cycle flag that ends the stop recovery delay |

## Verification
The oscillator tick is driven with random gaps, so the divide ratio is measured in ticks between enables and not in clock cycles. This separates a correct tick count from one that counts clock edges. The rate is measured under every pairing of speed setting and mode, and under each wake source. Pairing a slow setting with an interrupt wake-up, and then with a reset wake-up, shows whether the pre-wait rate is restored or cleared. A fast setting in wait shows whether the wait rate overrides the setting. A write made just after a period boundary shows whether a switch truncates the running period. Random speed writes to the matching address and to other addresses check that the decode ignores every other address.

// File: rtl/lpm_clk_pkg.sv
package lpm_clk_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Power mode of the controller.
  typedef enum logic [1:0] {
    MD_RUN   = 2'd0,
    MD_WAIT  = 2'd1,
    MD_STOP  = 2'd2,
    MD_RECOV = 2'd3
  } lpm_mode_e;
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0] sync_q;

  // Assert asynchronously, release after two clock edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lpm_spd_reg.sv
module lpm_spd_reg #(
  parameter int unsigned AW       = 8,
  parameter int unsigned SPD_ADDR = 'h21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_spd,
  input  logic          clr,
  output logic          spd
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [AW-1:0] MATCH = AW'(SPD_ADDR);

  logic spd_q, spd_d, hit;

  assign hit = wr_en && (wr_addr == MATCH);

  // A reset wake-up clears the setting and wins over a write in the same cycle.
  always_comb begin
    spd_d = spd_q;
    if (clr)      spd_d = 1'b0;
    else if (hit) spd_d = wr_spd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spd_q <= 1'b0;
    else        spd_q <= spd_d;
  end

  assign spd = spd_q;
endmodule

// File: rtl/lpm_clk_div.sv
module lpm_clk_div #(
  parameter int unsigned FAST_DIV = 5,
  parameter int unsigned SLOW_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic hold,
  input  logic want_slow,
  output logic tick_int,
  output logic act_slow
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);
  localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          slow_q, slow_d;

  assign lim      = slow_q ? SLOW_LIM : FAST_LIM;
  assign tick_int = osc_tick && !hold && (cnt_q == lim);

  // The ratio is reloaded only when a period completes.
  always_comb begin
    cnt_d  = cnt_q;
    slow_d = slow_q;
    if (hold) begin
      cnt_d  = '0;
      slow_d = 1'b1;
    end else if (tick_int) begin
      cnt_d  = '0;
      slow_d = want_slow;
    end else if (osc_tick) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      slow_q <= slow_d;
    end
  end

  assign act_slow = slow_q;
endmodule

// File: rtl/lpm_pwr_fsm.sv
module lpm_pwr_fsm
  import lpm_clk_pkg::*;
#(
  parameter int unsigned RECOV_CYC = 4064
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wait_req,
  input  logic      stop_req,
  input  logic      irq_wake,
  input  logic      tmr_wake,
  input  logic      tmr_wake_en,
  input  logic      rst_wake,
  input  logic      tick_int,
  output lpm_mode_e mode,
  output lpm_mode_e mode_nxt,
  output logic      spd_clr,
  output logic      imask_clr,
  output logic      recov_done
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned RCW = $clog2(RECOV_CYC + 1);
  localparam logic [RCW-1:0] RLAST = RCW'(RECOV_CYC - 1);

  lpm_mode_e      mode_q, mode_d;
  logic [RCW-1:0] rcnt_q, rcnt_d;
  logic           imask_q, imask_d;
  logic           rec_last, int_wake;

  assign int_wake = irq_wake || (tmr_wake && tmr_wake_en);
  assign rec_last = (mode_q == MD_RECOV) && tick_int && (rcnt_q == RLAST);

  always_comb begin
    mode_d  = mode_q;
    spd_clr = 1'b0;
    unique case (mode_q)
      MD_RUN: begin
        if (stop_req)      mode_d = MD_STOP;
        else if (wait_req) mode_d = MD_WAIT;
      end
      MD_WAIT: begin
        if (rst_wake) begin
          mode_d  = MD_RUN;
          spd_clr = 1'b1;
        end else if (int_wake) begin
          mode_d  = MD_RUN;
        end
      end
      MD_STOP: begin
        if (rst_wake) begin
          mode_d  = MD_RECOV;
          spd_clr = 1'b1;
        end else if (irq_wake) begin
          mode_d  = MD_RECOV;
        end
      end
      MD_RECOV: begin
        if (rec_last) mode_d = MD_RUN;
      end
      default: mode_d = MD_RUN;
    endcase
  end

  // Recovery delay counted in slow-rate CPU cycles.
  always_comb begin
    rcnt_d = rcnt_q;
    if (mode_q != MD_RECOV)  rcnt_d = '0;
    else if (rec_last)       rcnt_d = '0;
    else if (tick_int)       rcnt_d = rcnt_q + 1'b1;
  end

  assign imask_d = (mode_q == MD_RUN) && (mode_d == MD_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_RUN;
      rcnt_q  <= '0;
      imask_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      rcnt_q  <= rcnt_d;
      imask_q <= imask_d;
    end
  end

  assign mode       = mode_q;
  assign mode_nxt   = mode_d;
  assign imask_clr  = imask_q;
  assign recov_done = rec_last;
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_clk_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned SPD_ADDR  = 'h21,
  parameter int unsigned FAST_DIV  = 5,
  parameter int unsigned SLOW_MUL  = 8,
  parameter int unsigned RECOV_CYC = 4064
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_tick,
  input  logic          wait_req,
  input  logic          stop_req,
  input  logic          irq_wake,
  input  logic          tmr_wake,
  input  logic          tmr_wake_en,
  input  logic          rst_wake,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_spd,
  output logic          cpu_ce,
  output logic          imask_clr,
  output logic          recov_done
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned SLOW_DIV = FAST_DIV * SLOW_MUL;

  logic      srst_n;
  logic      spd_q, spd_clr;
  logic      tick_int, act_slow, want_slow, div_hold;
  lpm_mode_e mode, mode_nxt;

  lpm_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  lpm_spd_reg #(.AW(AW), .SPD_ADDR(SPD_ADDR)) u_spd (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_spd  (wr_spd),
    .clr     (spd_clr),
    .spd     (spd_q)
  );

  lpm_pwr_fsm #(.RECOV_CYC(RECOV_CYC)) u_fsm (
    .clk         (clk),
    .rst_n       (srst_n),
    .wait_req    (wait_req),
    .stop_req    (stop_req),
    .irq_wake    (irq_wake),
    .tmr_wake    (tmr_wake),
    .tmr_wake_en (tmr_wake_en),
    .rst_wake    (rst_wake),
    .tick_int    (tick_int),
    .mode        (mode),
    .mode_nxt    (mode_nxt),
    .spd_clr     (spd_clr),
    .imask_clr   (imask_clr),
    .recov_done  (recov_done)
  );

  // Rate request follows the mode being entered; the held setting is used in run.
  assign want_slow = (mode_nxt == MD_WAIT) || (mode_nxt == MD_RECOV) || spd_q;
  assign div_hold  = (mode == MD_STOP);

  lpm_clk_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
    .clk       (clk),
    .rst_n     (srst_n),
    .osc_tick  (osc_tick),
    .hold      (div_hold),
    .want_slow (want_slow),
    .tick_int  (tick_int),
    .act_slow  (act_slow)
  );

  assign cpu_ce = tick_int && ((mode == MD_RUN) || (mode == MD_WAIT));
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk
  import lpm_clk_pkg::*;
#(
  parameter int unsigned AW       = 8,
  parameter int unsigned SPD_ADDR = 'h21
) (
  input logic          clk,
  input logic          srst_n,
  input logic          osc_tick,
  input logic          cpu_ce,
  input logic          imask_clr,
  input logic          recov_done,
  input lpm_mode_e     mode,
  input logic          tick_int,
  input logic          div_hold,
  input logic          act_slow,
  input logic          spd_q,
  input logic          spd_clr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          irq_wake,
  input logic          tmr_wake_en,
  input logic          rst_wake
);
  timeunit 1ns;
  timeprecision 1ps;

  AST_CE_ON_TICK: assert property (@(posedge clk) disable iff (!srst_n)
    cpu_ce |-> osc_tick); // R1

  AST_SPD_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
    (!(wr_en && (wr_addr == AW'(SPD_ADDR))) && !spd_clr) |=> $stable(spd_q)); // R2

  AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!srst_n)
    (!tick_int && !div_hold) |=> $stable(act_slow)); // R3

  AST_MASK_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
    imask_clr |=> !imask_clr); // R4

  AST_MASK_IN_WAIT: assert property (@(posedge clk) disable iff (!srst_n)
    imask_clr |-> (mode == MD_WAIT)); // R4

  AST_TMR_MASKED: assert property (@(posedge clk) disable iff (!srst_n)
    ((mode == MD_WAIT) && !irq_wake && !rst_wake && !tmr_wake_en) |=> (mode == MD_WAIT)); // R5

  AST_RST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!srst_n)
    (rst_wake && ((mode == MD_WAIT) || (mode == MD_STOP))) |=> !spd_q); // R7

  AST_NO_CE_STOPPED: assert property (@(posedge clk) disable iff (!srst_n)
    ((mode == MD_STOP) || (mode == MD_RECOV)) |-> !cpu_ce); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
    recov_done |=> !recov_done); // R9

  AST_DONE_TO_RUN: assert property (@(posedge clk) disable iff (!srst_n)
    recov_done |=> (mode == MD_RUN)); // R9
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.AW(AW), .SPD_ADDR(SPD_ADDR)) u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .osc_tick    (osc_tick),
  .cpu_ce      (cpu_ce),
  .imask_clr   (imask_clr),
  .recov_done  (recov_done),
  .mode        (mode),
  .tick_int    (tick_int),
  .div_hold    (div_hold),
  .act_slow    (act_slow),
  .spd_q       (spd_q),
  .spd_clr     (spd_clr),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .irq_wake    (irq_wake),
  .tmr_wake_en (tmr_wake_en),
  .rst_wake    (rst_wake)
);

// File: tb/sim_lpm_clk_ctrl.sv
module sim_lpm_clk_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int RC   = 20;
  localparam int FAST = 5;
  localparam int SLOW = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc_tick, wait_req, stop_req, irq_wake, tmr_wake, tmr_wake_en, rst_wake;
  logic       wr_en, wr_spd;
  logic [7:0] wr_addr;
  logic       cpu_ce, imask_clr, recov_done;

  bit p_wait, p_stop, p_irq, p_tmr, p_rst, p_wr;
  int n_chk = 0;
  int n_err = 0;
  bit mdl_spd;

  always #2.5 clk = ~clk;

  lpm_clk_ctrl #(.RECOV_CYC(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .wait_req(wait_req),
    .stop_req(stop_req), .irq_wake(irq_wake), .tmr_wake(tmr_wake),
    .tmr_wake_en(tmr_wake_en), .rst_wake(rst_wake), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_spd(wr_spd), .cpu_ce(cpu_ce),
    .imask_clr(imask_clr), .recov_done(recov_done)
  );

  function automatic int exp_ratio(bit in_wait, bit spd);
    return (in_wait || spd) ? SLOW : FAST;
  endfunction

  function automatic bit rnd_tick();
    return ($urandom % 4) != 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle: pulses pending in p_* are applied for exactly this cycle.
  task automatic step(bit tick);
    @(negedge clk);
    osc_tick = tick;
    wait_req = p_wait; stop_req = p_stop; irq_wake = p_irq;
    tmr_wake = p_tmr;  rst_wake = p_rst;  wr_en    = p_wr;
    p_wait = 0; p_stop = 0; p_irq = 0; p_tmr = 0; p_rst = 0; p_wr = 0;
    #1;
  endtask

  task automatic align();
    int g = 0;
    do begin step(rnd_tick()); g++; end while (!cpu_ce && g < 2000);
  endtask

  // Ticks between successive enables, after aligning to one enable.
  task automatic measure(int n, int exp, string req);
    int got = 0, cnt = 0, g = 0, badv = 0;
    bit bad = 0;
    align();
    while (got < n && g < 20000) begin
      step(rnd_tick()); g++;
      if (osc_tick) cnt++;
      if (cpu_ce) begin
        if (cnt != exp && !bad) begin bad = 1; badv = cnt; end
        cnt = 0; got++;
      end
    end
    check(!bad && got == n, req, bad ? badv : (got == n ? exp : -1), exp);
  endtask

  task automatic write_spd(logic [7:0] a, bit v);
    wr_addr = a; wr_spd = v; p_wr = 1;
    step(rnd_tick());
    if (a == 8'h21) mdl_spd = v;
  endtask

  task automatic enter_wait(string req);
    p_wait = 1; step(rnd_tick());
    step(rnd_tick());
    check(imask_clr == 1'b1, req, imask_clr, 1);
    step(rnd_tick());
    check(imask_clr == 1'b0, req, imask_clr, 0);
  endtask

  task automatic recovery(string req);
    int cnt = 0, ce_n = 0, g = 0, at = -1;
    step(1'b1); // the wake cycle: divider is held
    while (g < 20000) begin
      step(rnd_tick()); g++;
      if (osc_tick) cnt++;
      if (cpu_ce) ce_n++;
      if (recov_done) begin at = cnt; break; end
    end
    check(at == RC * SLOW, req, at, RC * SLOW);
    check(ce_n == 0, req, ce_n, 0);
    step(rnd_tick());
    check(recov_done == 1'b0, req, recov_done, 0);
  endtask

  task automatic stop_quiet(string req);
    int ce_n = 0;
    p_stop = 1; step(rnd_tick());
    for (int i = 0; i < 120; i++) begin
      if (i == 30) p_wait = 1; // ignored while stopped
      step(rnd_tick());
      if (cpu_ce || imask_clr) ce_n++;
    end
    check(ce_n == 0, req, ce_n, 0);
  endtask

  initial begin
    #(150000 * 5);
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c05));
    rst_n = 0; osc_tick = 0; wait_req = 0; stop_req = 0; irq_wake = 0;
    tmr_wake = 0; tmr_wake_en = 0; rst_wake = 0; wr_en = 0; wr_addr = 0; wr_spd = 0;
    mdl_spd = 0;
    for (int i = 0; i < 4; i++) step(1'b1);
    check(!cpu_ce && !imask_clr && !recov_done, "R10 outputs in reset",
          {cpu_ce, imask_clr, recov_done}, 0);
    rst_n = 1;
    for (int i = 0; i < 3; i++) step(1'b0);
    check(!cpu_ce && !imask_clr && !recov_done, "R10 outputs after release",
          {cpu_ce, imask_clr, recov_done}, 0);
    measure(8, exp_ratio(0, 0), "R10 R1 reset rate");

    // R2: write to another address ignored
    write_spd(8'h20, 1'b1);
    measure(4, FAST, "R2 other address ignored");

    // R3: switch requested right after a boundary finishes at old length
    begin
      int cnt = 0, g = 0;
      align();
      write_spd(8'h21, 1'b1);
      if (osc_tick) cnt++;
      while (!cpu_ce && g < 2000) begin step(rnd_tick()); g++; if (osc_tick) cnt++; end
      check(cnt == FAST, "R3 period in progress keeps old ratio", cnt, FAST);
    end
    measure(4, exp_ratio(0, mdl_spd), "R2 slow rate in run");

    // R4 + R6: wait with slow setting, write fast during wait
    enter_wait("R4 mask clear pulse");
    measure(3, exp_ratio(1, mdl_spd), "R4 slow in wait");
    write_spd(8'h21, 1'b0);
    measure(3, SLOW, "R6 write held during wait");
    p_irq = 1; step(rnd_tick());
    measure(4, exp_ratio(0, mdl_spd), "R6 write applied after wake");

    // R5: timer wake masked, then enabled
    enter_wait("R4 mask clear pulse again");
    measure(2, SLOW, "R4 wait overrides fast setting");
    p_tmr = 1; step(rnd_tick());
    measure(3, SLOW, "R5 masked timer ignored");
    tmr_wake_en = 1;
    p_tmr = 1; step(rnd_tick());
    measure(3, FAST, "R5 timer wake");
    tmr_wake_en = 0;

    // R5: interrupt restores slow pre-wait rate
    write_spd(8'h21, 1'b1);
    enter_wait("R4 mask clear slow");
    p_irq = 1; step(rnd_tick());
    measure(3, exp_ratio(0, mdl_spd), "R5 pre-wait rate restored");

    // R7: reset wake from wait clears setting
    enter_wait("R4 mask clear before reset wake");
    p_rst = 1; step(rnd_tick()); mdl_spd = 0;
    measure(4, exp_ratio(0, mdl_spd), "R7 reset wake from wait");

    // R8 + R9: stop, interrupt wake
    stop_quiet("R8 no clock while stopped");
    p_irq = 1;
    recovery("R9 interrupt recovery");
    measure(4, FAST, "R9 clock resumes");

    // R7 + R9: stop with slow setting, reset wake
    write_spd(8'h21, 1'b1);
    stop_quiet("R8 no clock while stopped slow");
    p_rst = 1; mdl_spd = 0;
    recovery("R9 reset recovery");
    measure(4, exp_ratio(0, mdl_spd), "R7 reset wake from stop");

    // R2 random writes
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a = (($urandom % 2) == 0) ? 8'h21 : 8'($urandom % 256);
      write_spd(a, 1'($urandom % 2));
      measure(3, exp_ratio(0, mdl_spd), "R2 random write");
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule